// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns an addressing-mode selector, a mode bit, the next-instruction program counter and an instruction operand field into a final operand or branch-target address. The address space is 24 bits wide. The result is presented on a 32-bit output whose top byte is always zero. A mode bit picks between a narrow 16-bit space and a wide 24-bit space. That choice changes how the short absolute forms are mapped and how wide the indirect pointer fetch is.

Absolute and program-counter-relative kinds settle combinationally. They present their address with a valid strobe in the same cycle as the start strobe. The memory-indirect kind zero-extends an 8-bit field into a pointer in the bottom 256 bytes. It reads the jump target through a request/acknowledge memory port and reports the target with a single-cycle valid strobe. The block is busy while the fetch runs, and it flags any branch or jump target that is odd.

Top module: `ea_gen_unit`

## Requirements
- R1: With kind_i = 0 (8-bit absolute), addr_o holds the byte field_i[7:0] placed in the top page: 0x00FFFF00 | byte when adv_i = 1, and 0x0000FF00 | byte when adv_i = 0.
- R2: With kind_i = 1 (16-bit absolute), addr_o is field_i[15:0] zero-extended when adv_i = 0. When adv_i = 1 it is field_i[15:0] sign-extended to 24 bits, giving 0x000000–0x007FFF or 0xFF8000–0xFFFFFF.
- R3: With kind_i = 2 or 3 (24-bit or 32-bit absolute), addr_o is field_i[23:0] and bits 31:24 are zero. Whenever valid_o is high, addr_o[31:24] is zero.
- R4: With kind_i = 4 or 5, the displacement is field_i[7:0] (kind 4) or field_i[15:0] (kind 5). It is sign-extended and added to pc_i, which is the address of the next instruction. Only the low 24 bits of the sum are kept, so the sum wraps at the 24-bit boundary.
- R5: odd_o is high exactly when valid_o is high, the result is a branch or jump target (kind 4, 5 or 6), and addr_o[0] is 1. It is never high for the absolute kinds.
- R6: For kinds 0–5, valid_o is high in the same cycle as start_i while the block is not busy. Kind 6 gives no valid in its start cycle. Kind 7 is reserved and never gives valid.
- R7: With kind_i = 6, mem_req_o rises in the cycle after start. mem_addr_o carries field_i[7:0] and mem_wide_o carries adv_i. The request stays high until the first cycle in which mem_ack_i is high. An acknowledge in the first request cycle is accepted.
- R8: valid_o pulses for one cycle, in the cycle after the acknowledge. addr_o is then mem_rdata_i[15:0] zero-extended when adv_i was 0, or mem_rdata_i[23:0] when adv_i was 1.
- R9: busy_o is high from the cycle after an indirect start through its valid cycle. A start_i of any kind while busy gives no extra valid and leaves mem_addr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one address computation |
| kind_i | input | 3 | Address kind selector (0–7) |
| adv_i | input | 1 | 1 = 24-bit space, 0 = 16-bit space |
| pc_i | input | 24 | Address of the next instruction |
| field_i | input | 32 | Immediate, absolute or displacement field |
| mem_req_o | output | 1 | Indirect read request |
| mem_addr_o | output | 8 | Indirect pointer address |
| mem_wide_o | output | 1 | 1 = 32-bit read, 0 = 16-bit read |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 32 | Read data |
| addr_o | output | 32 | Computed address |
| valid_o | output | 1 | addr_o is valid this cycle |
| odd_o | output | 1 | Branch or jump target is odd |
| busy_o | output | 1 | Indirect fetch in progress |

## Verification
Two things can meet in one cycle. A fresh start strobe can arrive while an indirect fetch is still waiting or is already reporting its result. Separately, the acknowledge can come in the very first request cycle. The bench provokes the first case by raising start with a direct kind during the wait cycles and again in the cycle that carries the fetched target. It judges that valid_o and addr_o reflect only the fetch, and that the pointer never moves. It provokes the second by acknowledging at once, and expects the target one cycle later with no dead cycle in between.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    K_ABS8  = 3'd0,
    K_ABS16 = 3'd1,
    K_ABS24 = 3'd2,
    K_ABS32 = 3'd3,
    K_REL8  = 3'd4,
    K_REL16 = 3'd5,
    K_IND8  = 3'd6,
    K_RSV   = 3'd7
  } ea_kind_e;

  typedef enum logic [1:0] {
    S_IDLE, S_REQ, S_WAIT, S_DONE
  } fetch_state_e;
endpackage

// File: rtl/ea_direct_calc.sv
module ea_direct_calc
  import ea_pkg::*;
#(
  parameter int AW = 24,
  parameter int NW = 16,
  parameter int OW = 32,
  parameter int PW = 8
) (
  input  ea_kind_e        kind_i,
  input  logic            adv_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [OW-1:0]   field_i,
  output logic [OW-1:0]   addr_o,
  output logic            ok_o,
  output logic            branch_o
);
  localparam int HW = OW - AW;

  logic [AW-1:0] disp8, disp16, sum8, sum16;

  assign disp8  = {{(AW-8){field_i[7]}}, field_i[7:0]};
  assign disp16 = {{(AW-16){field_i[15]}}, field_i[15:0]};
  assign sum8   = pc_i + disp8;   // wraps at 24 bits
  assign sum16  = pc_i + disp16;

  always_comb begin
    addr_o   = '0;
    ok_o     = 1'b1;
    branch_o = 1'b0;
    unique case (kind_i)
      K_ABS8:  addr_o = adv_i ? {{HW{1'b0}}, {(AW-PW){1'b1}}, field_i[PW-1:0]}
                              : {{(OW-NW){1'b0}}, {(NW-PW){1'b1}}, field_i[PW-1:0]};
      K_ABS16: addr_o = adv_i ? {{HW{1'b0}}, {(AW-NW){field_i[NW-1]}}, field_i[NW-1:0]}
                              : {{(OW-NW){1'b0}}, field_i[NW-1:0]};
      K_ABS24,
      K_ABS32: addr_o = {{HW{1'b0}}, field_i[AW-1:0]};
      K_REL8:  begin addr_o = {{HW{1'b0}}, sum8};  branch_o = 1'b1; end
      K_REL16: begin addr_o = {{HW{1'b0}}, sum16}; branch_o = 1'b1; end
      default: ok_o = 1'b0;  // indirect or reserved
    endcase
  end
endmodule

// File: rtl/ea_indirect_fsm.sv
module ea_indirect_fsm
  import ea_pkg::*;
#(
  parameter int AW = 24,
  parameter int NW = 16,
  parameter int OW = 32,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          adv_i,
  input  logic [PW-1:0] ptr_i,
  input  logic          ack_i,
  input  logic [OW-1:0] rdata_i,
  output logic          req_o,
  output logic [PW-1:0] ptr_o,
  output logic          wide_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [OW-1:0] target_o
);
  fetch_state_e state_q;
  logic [PW-1:0] ptr_q;
  logic          wide_q;
  logic [OW-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      wide_q  <= 1'b0;
      tgt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (launch_i) begin
          state_q <= S_REQ;
          ptr_q   <= ptr_i;
          wide_q  <= adv_i;
        end
        S_REQ, S_WAIT: if (ack_i) begin
          state_q <= S_DONE;
          tgt_q   <= wide_q ? {{(OW-AW){1'b0}}, rdata_i[AW-1:0]}
                            : {{(OW-NW){1'b0}}, rdata_i[NW-1:0]};
        end else begin
          state_q <= S_WAIT;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_o    = (state_q == S_REQ) || (state_q == S_WAIT);
  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign ptr_o    = ptr_q;
  assign wide_o   = wide_q;
  assign target_o = tgt_q;
endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_pkg::*;
#(
  parameter int AW = 24,
  parameter int NW = 16,
  parameter int OW = 32,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    kind_i,
  input  logic          adv_i,
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] field_i,
  output logic          mem_req_o,
  output logic [PW-1:0] mem_addr_o,
  output logic          mem_wide_o,
  input  logic          mem_ack_i,
  input  logic [OW-1:0] mem_rdata_i,
  output logic [OW-1:0] addr_o,
  output logic          valid_o,
  output logic          odd_o,
  output logic          busy_o
);
  ea_kind_e      kind;
  logic [OW-1:0] dir_addr, ind_addr;
  logic          dir_ok, dir_branch, ind_done, ind_busy, launch;
  logic          unused_bits;

  assign kind        = ea_kind_e'(kind_i);
  assign unused_bits = ^{field_i[OW-1:AW], mem_rdata_i[OW-1:AW]};
  assign launch      = start_i && !ind_busy && (kind == K_IND8);

  ea_direct_calc #(.AW(AW), .NW(NW), .OW(OW), .PW(PW)) i_direct (
    .kind_i   (kind),
    .adv_i    (adv_i),
    .pc_i     (pc_i),
    .field_i  (field_i),
    .addr_o   (dir_addr),
    .ok_o     (dir_ok),
    .branch_o (dir_branch)
  );

  ea_indirect_fsm #(.AW(AW), .NW(NW), .OW(OW), .PW(PW)) i_indirect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .adv_i    (adv_i),
    .ptr_i    (field_i[PW-1:0]),
    .ack_i    (mem_ack_i),
    .rdata_i  (mem_rdata_i),
    .req_o    (mem_req_o),
    .ptr_o    (mem_addr_o),
    .wide_o   (mem_wide_o),
    .busy_o   (ind_busy),
    .done_o   (ind_done),
    .target_o (ind_addr)
  );

  // Indirect result wins; direct start is ignored while busy
  assign valid_o = ind_done || (start_i && !ind_busy && dir_ok);
  assign addr_o  = ind_done ? ind_addr : dir_addr;
  assign odd_o   = valid_o && addr_o[0] && (ind_done || dir_branch);
  assign busy_o  = ind_busy;
endmodule

// File: rtl/ea_gen_checker.sv
module ea_gen_checker #(
  parameter int AW = 24,
  parameter int OW = 32,
  parameter int PW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [PW-1:0] mem_addr_o,
  input logic [OW-1:0] addr_o,
  input logic          valid_o,
  input logic          odd_o,
  input logic          busy_o
);
  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o);

  assert_req_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  assert_valid_after_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> valid_o && busy_o && !mem_req_o);

  assert_busy_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && valid_o |=> !busy_o);

  assert_ptr_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mem_addr_o));

  assert_odd_needs_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_o |-> valid_o);

  assert_top_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> addr_o[OW-1:AW] == '0);
endmodule

bind ea_gen_unit ea_gen_checker #(.AW(AW), .OW(OW), .PW(PW)) i_ea_gen_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o),
  .addr_o     (addr_o),
  .valid_o    (valid_o),
  .odd_o      (odd_o),
  .busy_o     (busy_o)
);

// File: tb/test_ea_gen_unit.sv
module test_ea_gen_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic        adv = 1'b0;
  logic [23:0] pc = '0;
  logic [31:0] field = '0;
  logic        mem_req, mem_wide, mem_ack = 1'b0;
  logic [7:0]  mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [31:0] addr;
  logic        valid, odd, busy;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ea_gen_unit i_ea_gen_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .kind_i(kind), .adv_i(adv),
    .pc_i(pc), .field_i(field), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_wide_o(mem_wide), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .addr_o(addr), .valid_o(valid), .odd_o(odd), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", cyc, 190000);
      finish_run();
    end
  end

  task automatic direct(input logic [2:0] k, input logic a, input logic [23:0] p,
                        input logic [31:0] f, input logic [31:0] exp, input bit br, input string req);
    @(negedge clk);
    start = 1'b1; kind = k; adv = a; pc = p; field = f;
    #1;
    chk(valid === 1'b1, req, {31'd0, valid}, 32'd1);
    chk(addr === exp, req, addr, exp);
    chk(odd === (br & exp[0]), "R5", {31'd0, odd}, {31'd0, br & exp[0]});
  endtask

  task automatic indirect(input logic a, input logic [7:0] ptr, input logic [31:0] data,
                          input int waits, input bit poke);
    logic [31:0] exp;
    exp = a ? {8'h00, data[23:0]} : {16'h0000, data[15:0]};
    @(negedge clk);
    start = 1'b1; kind = 3'd6; adv = a; field = {24'hA5C3E1, ptr};
    #1;
    chk(valid === 1'b0, "R6 indirect start", {31'd0, valid}, 32'd0);
    @(negedge clk);
    start = 1'b0; adv = ~a; mem_ack = (waits == 0); mem_rdata = data;
    #1;
    chk(mem_req === 1'b1 && busy === 1'b1, "R7 req", {30'd0, mem_req, busy}, 32'd3);
    chk(mem_addr === ptr, "R7 ptr", {24'd0, mem_addr}, {24'd0, ptr});
    chk(mem_wide === a, "R7 wide", {31'd0, mem_wide}, {31'd0, a});
    for (int i = 1; i <= waits; i++) begin
      @(negedge clk);
      start = poke; kind = 3'd0; field = 32'h0000_0011; mem_ack = (i == waits);
      #1;
      chk(mem_req === 1'b1, "R7 hold", {31'd0, mem_req}, 32'd1);
      chk(valid === 1'b0, "R9 ignored start", {31'd0, valid}, 32'd0);
      chk(mem_addr === ptr, "R9 ptr stable", {24'd0, mem_addr}, {24'd0, ptr});
    end
    @(negedge clk);
    mem_ack = 1'b0; mem_rdata = ~data; start = poke; kind = 3'd1; field = 32'h0000_1235;
    #1;
    chk(valid === 1'b1 && busy === 1'b1, "R8 valid", {30'd0, valid, busy}, 32'd3);
    chk(addr === exp, "R8 target", addr, exp);
    chk(odd === exp[0], "R5 indirect odd", {31'd0, odd}, {31'd0, exp[0]});
    chk(mem_req === 1'b0, "R7 req drop", {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(valid === 1'b0 && busy === 1'b0, "R9 release", {30'd0, valid, busy}, 32'd0);
  endtask

  initial begin
    #2;
    chk(valid === 1'b0 && busy === 1'b0 && mem_req === 1'b0, "reset", {29'd0, valid, busy, mem_req}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 full byte sweep, both modes
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 256; b++)
        direct(3'd0, m[0], 24'h123456, {24'hDEAD00, b[7:0]},
               m[0] ? (32'h00FFFF00 | b) : (32'h0000FF00 | b), 1'b0, "R1");

    // R2 16-bit absolute sweep plus both sign boundaries
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 65536; v += 241) begin
        logic [15:0] w;
        w = v[15:0];
        direct(3'd1, m[0], 24'h0, {16'hBEEF, w},
               m[0] ? {8'h00, {8{w[15]}}, w} : {16'h0, w}, 1'b0, "R2");
      end
      direct(3'd1, m[0], 24'h0, 32'h0000_7FFF, 32'h0000_7FFF, 1'b0, "R2 top positive");
      direct(3'd1, m[0], 24'h0, 32'h0000_8000, m[0] ? 32'h00FF_8000 : 32'h0000_8000, 1'b0, "R2 first negative");
    end

    // R3 24/32-bit absolute
    for (int k = 2; k < 4; k++)
      for (int v = 0; v < 64; v++) begin
        logic [31:0] f;
        f = 32'h9E37_79B9 * (v + 1);
        direct(k[2:0], v[0], 24'h0, f, {8'h00, f[23:0]}, 1'b0, "R3");
      end

    // R4 8-bit displacement sweep at three PCs incl. wrap both ways
    for (int pi = 0; pi < 3; pi++) begin
      logic [23:0] p;
      p = (pi == 0) ? 24'h001000 : (pi == 1) ? 24'hFFFFF0 : 24'h000005;
      for (int d = 0; d < 256; d++) begin
        logic [31:0] s;
        s = ({8'h0, p} + {{24{d[7]}}, d[7:0]}) & 32'h00FF_FFFF;
        direct(3'd4, pi[0], p, {24'h777777, d[7:0]}, s, 1'b1, "R4 d8");
      end
    end
    // R4 16-bit displacement
    for (int d = 0; d < 65536; d += 257) begin
      logic [31:0] s;
      s = ({8'h0, 24'hFF8002} + {{16{d[15]}}, d[15:0]}) & 32'h00FF_FFFF;
      direct(3'd5, d[0], 24'hFF8002, {16'h4242, d[15:0]}, s, 1'b1, "R4 d16");
    end
    direct(3'd5, 1'b1, 24'h000002, 32'h0000_8000, 32'h00FF_8002, 1'b1, "R4 d16 min");

    // R6 reserved kind never valid
    @(negedge clk); start = 1'b1; kind = 3'd7; field = 32'h0;
    #1; chk(valid === 1'b0, "R6 reserved", {31'd0, valid}, 32'd0);
    @(negedge clk); start = 1'b0;

    // R7/R8/R9 indirect: immediate ack, waits, collisions, odd targets
    indirect(1'b0, 8'h00, 32'hCAFE_1234, 0, 1'b0);
    indirect(1'b1, 8'hFF, 32'hAB12_3457, 0, 1'b1);
    indirect(1'b0, 8'h5A, 32'h0012_BEEF, 3, 1'b1);
    indirect(1'b1, 8'h81, 32'hFF80_0000, 5, 1'b0);
    indirect(1'b1, 8'h3C, 32'h0000_0001, 2, 1'b1);

    finish_run();
  end
endmodule